// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a two-way set-associative read cache. It spends no more than one tag comparator on the common case. Each set stores one steering bit that names the way expected to hold the next requested block. On the first lookup cycle, the data multiplexer and the single comparator are both pointed at that way. A correct guess therefore completes in the time of a direct-mapped lookup. A wrong guess costs one steering cycle to turn the multiplexer round, and then a comparison against the remaining way. Only when that second comparison also fails is the request treated as a miss, and the block is then fetched through a one-word fill port.

The processor side raises `cpu_req` for one cycle with a block address while the cache is idle. It receives one `cpu_done` pulse together with `cpu_rdata`. On a miss, the refilled block replaces the way that was not predicted, and the steering bit moves to it. On a hit in the non-predicted way, the steering bit flips to that way. Three event counters, for fast hits, slow hits and misses, let a user measure the mix of latencies.

The controller has five states. IDLE waits for a request and moves to PRED when `cpu_req` is high. PRED compares against the predicted way: a hit returns to IDLE and a mismatch moves to STEER. STEER always moves on to ALT. ALT compares against the other way: a hit returns to IDLE and a mismatch moves to FILL. FILL holds the memory request until `mem_valid` arrives, then returns to IDLE.

Top module: `wp_cache`

## Requirements
- R1: After reset, `cpu_done` and `mem_req` are low, all three counters read zero and every line is invalid, so the first access to any address is a miss.
- R2: When the predicted way holds the block, `cpu_done` is high in the cycle after the clock edge that accepted the request, `cpu_rdata` carries the block, and `cnt_fast` rises by one.
- R3: When only the non-predicted way holds the block, `cpu_done` comes three cycles after the accepting edge with the block, and `cnt_slow` rises by one.
- R4: A slow hit flips the set's prediction, so an immediate repeat of the same address is a one-cycle hit.
- R5: On a miss, `mem_req` rises three cycles after the accepting edge with `mem_addr` equal to the requested block address. Both stay unchanged until `mem_valid` is sampled high.
- R6: The clock edge that samples `mem_valid` high ends the fill. In the next cycle `cpu_done` is high with `cpu_rdata` equal to `mem_data`, `cnt_miss` has risen by one and `mem_req` is low. The refilled block is then the predicted one, so it hits in one cycle.
- R7: A refill replaces the way that was not predicted at the time of the miss. The predicted block survives, and the displaced block misses on its next access.
- R8: `cpu_req` is ignored unless the controller is idle. A request raised during a lookup causes no extra `cpu_done`, no memory request and no counter change.
- R9: `cpu_done` lasts exactly one cycle, and each pulse advances exactly one of the three counters. No counter moves in any other cycle.
- R10: `mem_valid` outside a fill is ignored: it causes no done pulse, no counter change and no change to cached contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request strobe, sampled only while idle |
| cpu_addr | input | ADDR_W | Block address; low IDX_W bits select the set |
| cpu_rdata | output | DATA_W | Returned block, valid while `cpu_done` is high |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Fill request, held until `mem_valid` |
| mem_addr | output | ADDR_W | Block address being fetched |
| mem_valid | input | 1 | Fill data present this cycle |
| mem_data | input | DATA_W | Fill data |
| cnt_fast | output | CNT_W | Count of first-cycle hits |
| cnt_slow | output | CNT_W | Count of second-way hits |
| cnt_miss | output | CNT_W | Count of completed refills |

## Verification
A corrupted steering bit does not produce wrong data. It shows up as a latency change: a request that should finish after one cycle finishes after three, and the slow counter moves instead of the fast one. Both are visible on the very next access to that set. A wrong victim choice stays hidden until the displaced block is requested again. The bench therefore replays accesses to three tags mapped to one set, so that a misplaced refill turns an expected hit into a `mem_req`. Damage to a tag or valid bit appears either as a spurious fill request three cycles after acceptance or as wrong `cpu_rdata` on the done pulse.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRED,
        ST_STEER,
        ST_ALT,
        ST_FILL
    } wpc_state_e;
endpackage

// File: rtl/wpc_tag_store.sv
`timescale 1ns/1ps
// Tags, valid bits and per-set steering bit; one read port steered by way.
module wpc_tag_store #(
    parameter int SETS  = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_way,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_pred,
    input  logic             fill_we,
    input  logic             fill_way,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             pred_we,
    input  logic [IDX_W-1:0] pred_idx,
    input  logic             pred_val
);
    localparam int WAYS = 2;

    logic [TAG_W-1:0] tag_q [WAYS][SETS];
    logic [SETS-1:0]  vld_q [WAYS];
    logic [SETS-1:0]  pred_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                vld_q[w] <= '0;
            end
            pred_q <= '0;
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (fill_we && (fill_way == w[0])) begin
                    vld_q[w][fill_idx] <= 1'b1;
                end
            end
            if (pred_we) begin
                pred_q[pred_idx] <= pred_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (fill_we && (fill_way == w[0])) begin
                tag_q[w][fill_idx] <= fill_tag;
            end
        end
    end

    assign rd_tag   = tag_q[rd_way][rd_idx];
    assign rd_valid = vld_q[rd_way][rd_idx];
    assign rd_pred  = pred_q[rd_idx];
endmodule

// File: rtl/wpc_data_store.sv
`timescale 1ns/1ps
// One data array per way, read through a way-steered multiplexer.
module wpc_data_store #(
    parameter int SETS   = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_way,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int WAYS = 2;

    logic [WAYS*DATA_W-1:0] way_bus;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] mem_q [SETS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                mem_q[wr_idx] <= wr_data;
            end
        end
        assign way_bus[w*DATA_W +: DATA_W] = mem_q[rd_idx];
    end

    assign rd_data = way_bus[rd_way*DATA_W +: DATA_W];
endmodule

// File: rtl/wpc_perf.sv
`timescale 1ns/1ps
// Event counters for the three completion kinds.
module wpc_perf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_fast,
    input  logic             ev_slow,
    input  logic             ev_miss,
    output logic [CNT_W-1:0] cnt_fast,
    output logic [CNT_W-1:0] cnt_slow,
    output logic [CNT_W-1:0] cnt_miss
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_fast <= '0;
            cnt_slow <= '0;
            cnt_miss <= '0;
        end else begin
            if (ev_fast) cnt_fast <= cnt_fast + 1'b1;
            if (ev_slow) cnt_slow <= cnt_slow + 1'b1;
            if (ev_miss) cnt_miss <= cnt_miss + 1'b1;
        end
    end
endmodule

// File: rtl/wpc_ctrl.sv
`timescale 1ns/1ps
// Lookup sequencer: predicted check, steer, alternate check, refill.
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    output logic [IDX_W-1:0]  look_idx,
    output logic              look_way,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic              look_valid,
    input  logic              look_pred,
    input  logic [DATA_W-1:0] look_data,
    output logic              fill_we,
    output logic              fill_way,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              pred_we,
    output logic              pred_val,
    output logic              ev_fast,
    output logic              ev_slow,
    output logic              ev_miss
);
    wpc_state_e        state_q, state_d;
    logic [TAG_W-1:0]  req_tag_q;
    logic [IDX_W-1:0]  req_idx_q;
    logic              match;
    logic              finish;
    logic [DATA_W-1:0] finish_data;

    // The one comparator, shared by both check states.
    assign match    = look_valid && (look_tag == req_tag_q);
    assign look_idx = req_idx_q;
    assign look_way = (state_q == ST_PRED) ? look_pred : ~look_pred;
    assign fill_way = ~look_pred;
    assign fill_tag = req_tag_q;
    assign pred_val = ~look_pred;
    assign mem_req  = (state_q == ST_FILL);
    assign mem_addr = {req_tag_q, req_idx_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        finish      = 1'b0;
        finish_data = look_data;
        fill_we     = 1'b0;
        pred_we     = 1'b0;
        ev_fast     = 1'b0;
        ev_slow     = 1'b0;
        ev_miss     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_PRED;
            end
            ST_PRED: begin
                if (match) begin
                    finish  = 1'b1;
                    ev_fast = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_STEER;
                end
            end
            ST_STEER: begin
                state_d = ST_ALT;
            end
            ST_ALT: begin
                if (match) begin
                    finish  = 1'b1;
                    ev_slow = 1'b1;
                    pred_we = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_valid) begin
                    finish      = 1'b1;
                    finish_data = mem_data;
                    fill_we     = 1'b1;
                    pred_we     = 1'b1;
                    ev_miss     = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tag_q <= '0;
            req_idx_q <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            if ((state_q == ST_IDLE) && cpu_req) begin
                req_tag_q <= cpu_addr[ADDR_W-1:IDX_W];
                req_idx_q <= cpu_addr[IDX_W-1:0];
            end
            cpu_done <= finish;
            if (finish) cpu_rdata <= finish_data;
        end
    end
endmodule

// File: rtl/wp_cache.sv
`timescale 1ns/1ps
module wp_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    output logic [CNT_W-1:0]  cnt_fast,
    output logic [CNT_W-1:0]  cnt_slow,
    output logic [CNT_W-1:0]  cnt_miss
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  look_idx;
    logic              look_way, look_valid, look_pred;
    logic [TAG_W-1:0]  look_tag, fill_tag;
    logic [DATA_W-1:0] look_data;
    logic              fill_we, fill_way, pred_we, pred_val;
    logic              ev_fast, ev_slow, ev_miss;

    wpc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data),
        .look_idx(look_idx), .look_way(look_way),
        .look_tag(look_tag), .look_valid(look_valid),
        .look_pred(look_pred), .look_data(look_data),
        .fill_we(fill_we), .fill_way(fill_way), .fill_tag(fill_tag),
        .pred_we(pred_we), .pred_val(pred_val),
        .ev_fast(ev_fast), .ev_slow(ev_slow), .ev_miss(ev_miss)
    );

    wpc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(look_idx), .rd_way(look_way),
        .rd_tag(look_tag), .rd_valid(look_valid), .rd_pred(look_pred),
        .fill_we(fill_we), .fill_way(fill_way), .fill_idx(look_idx),
        .fill_tag(fill_tag),
        .pred_we(pred_we), .pred_idx(look_idx), .pred_val(pred_val)
    );

    wpc_data_store #(.SETS(SETS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_idx(look_idx), .rd_way(look_way), .rd_data(look_data),
        .wr_en(fill_we), .wr_way(fill_way), .wr_idx(look_idx),
        .wr_data(mem_data)
    );

    wpc_perf #(.CNT_W(CNT_W)) u_perf (
        .clk(clk), .rst_n(rst_n),
        .ev_fast(ev_fast), .ev_slow(ev_slow), .ev_miss(ev_miss),
        .cnt_fast(cnt_fast), .cnt_slow(cnt_slow), .cnt_miss(cnt_miss)
    );
endmodule

// File: rtl/wp_cache_chk.sv
`timescale 1ns/1ps
module wp_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  cnt_fast,
    input logic [CNT_W-1:0]  cnt_slow,
    input logic [CNT_W-1:0]  cnt_miss
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    a_r9_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> ($countones({cnt_fast != $past(cnt_fast),
                                  cnt_slow != $past(cnt_slow),
                                  cnt_miss != $past(cnt_miss)}) == 1));

    a_r9_counters_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_done |-> ($stable(cnt_fast) && $stable(cnt_slow) && $stable(cnt_miss)));

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> mem_req);

    a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> $stable(mem_addr));

    a_r6_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (cpu_done && !mem_req));

    a_r6_no_done_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_done);
endmodule

bind wp_cache wp_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_wp_cache.sv
`timescale 1ns/1ps
module test_wp_cache;
    localparam int KIND_FAST = 0;
    localparam int KIND_SLOW = 1;
    localparam int KIND_MISS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_done;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_data = '0;
    logic [15:0] cnt_fast, cnt_slow, cnt_miss;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wp_cache i_wp_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data),
        .cnt_fast(cnt_fast), .cnt_slow(cnt_slow), .cnt_miss(cnt_miss)
    );

    function automatic logic [31:0] backing(input logic [15:0] a);
        return {a, ~a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One access; checks latency, data, counters and the following cycle.
    task automatic do_access(input logic [15:0] a, input int kind, input int wait_c,
                             input bit poke, input string req);
        logic [15:0] f0, s0, m0;
        int n, req_seen, exp_lat;
        bit got;
        f0 = cnt_fast; s0 = cnt_slow; m0 = cnt_miss;
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a;
        @(posedge clk);
        #1 cpu_req = 1'b0; cpu_addr = '0;
        n = 0; got = 1'b0; req_seen = -1;
        while (!got && n < 40) begin
            @(posedge clk); n++; #1;
            if (poke && n == 1) begin cpu_req = 1'b1; cpu_addr = 16'hBEEF; end
            else if (poke && n == 2) begin cpu_req = 1'b0; cpu_addr = '0; end
            if (mem_valid) mem_valid = 1'b0;
            if (cpu_done) got = 1'b1;
            else if (mem_req) begin
                if (req_seen < 0) begin
                    req_seen = n;
                    check(n == 3, "R5", "fill request cycle", n, 3);
                    check(mem_addr == a, "R5", "fill address", mem_addr, a);
                end
                if (n - req_seen == wait_c) begin
                    mem_valid = 1'b1; mem_data = backing(a);
                end
            end
        end
        exp_lat = (kind == KIND_FAST) ? 1 : (kind == KIND_SLOW) ? 3 : 4 + wait_c;
        check(got, req, "done seen", got, 1);
        check(n == exp_lat, req, "latency", n, exp_lat);
        check(cpu_rdata == backing(a), req, "read data", cpu_rdata, backing(a));
        if (kind != KIND_MISS) check(req_seen < 0, req, "no fill on hit", req_seen, -1);
        check(cnt_fast == f0 + 16'(kind == KIND_FAST), req, "cnt_fast", cnt_fast, f0 + 16'(kind == KIND_FAST));
        check(cnt_slow == s0 + 16'(kind == KIND_SLOW), req, "cnt_slow", cnt_slow, s0 + 16'(kind == KIND_SLOW));
        check(cnt_miss == m0 + 16'(kind == KIND_MISS), req, "cnt_miss", cnt_miss, m0 + 16'(kind == KIND_MISS));
        @(posedge clk); #1;
        check(!cpu_done, "R9", "done pulse one cycle", cpu_done, 0);
        if (kind == KIND_MISS) check(!mem_req, "R6", "mem_req dropped", mem_req, 0);
    endtask

    task automatic test_reset();
        check(!cpu_done, "R1", "done after reset", cpu_done, 0);
        check(!mem_req, "R1", "mem_req after reset", mem_req, 0);
        check(cnt_fast == 0 && cnt_slow == 0 && cnt_miss == 0, "R1", "counters after reset",
              cnt_fast + cnt_slow + cnt_miss, 0);
    endtask

    task automatic test_busy_ignore();
        logic [15:0] f0, s0, m0;
        bit extra;
        // set 1: way0 holds 0x0021, way1 holds 0x0011, prediction way0
        do_access(16'h0011, KIND_SLOW, 0, 1'b1, "R8");
        f0 = cnt_fast; s0 = cnt_slow; m0 = cnt_miss;
        extra = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (cpu_done || mem_req) extra = 1'b1;
        end
        check(!extra, "R8", "no activity from busy request", extra, 0);
        check(cnt_fast == f0 && cnt_slow == s0 && cnt_miss == m0, "R8", "counters unchanged",
              cnt_fast + cnt_slow + cnt_miss, f0 + s0 + m0);
        do_access(16'h0011, KIND_FAST, 0, 1'b0, "R4");
    endtask

    task automatic test_stray_valid();
        logic [15:0] f0, s0, m0;
        bit extra;
        f0 = cnt_fast; s0 = cnt_slow; m0 = cnt_miss;
        @(negedge clk);
        mem_valid = 1'b1; mem_data = 32'hDEAD_BEEF;
        @(negedge clk);
        mem_valid = 1'b0;
        extra = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            if (cpu_done) extra = 1'b1;
        end
        check(!extra, "R10", "no done from stray valid", extra, 0);
        check(cnt_fast == f0 && cnt_slow == s0 && cnt_miss == m0, "R10", "counters unchanged",
              cnt_fast + cnt_slow + cnt_miss, f0 + s0 + m0);
        do_access(16'h0005, KIND_FAST, 0, 1'b0, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 test_reset();
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        test_reset();
        // Three tags sharing set 1: 0x0011, 0x0021, 0x0031
        do_access(16'h0011, KIND_MISS, 2, 1'b0, "R1");   // cold: way1, pred->1
        do_access(16'h0011, KIND_FAST, 0, 1'b0, "R6");   // refill now predicted
        do_access(16'h0011, KIND_FAST, 0, 1'b0, "R2");
        do_access(16'h0021, KIND_MISS, 0, 1'b0, "R6");   // way0, pred->0
        do_access(16'h0021, KIND_FAST, 0, 1'b0, "R2");
        do_access(16'h0011, KIND_SLOW, 0, 1'b0, "R3");   // pred->1
        do_access(16'h0011, KIND_FAST, 0, 1'b0, "R4");
        do_access(16'h0031, KIND_MISS, 5, 1'b0, "R7");   // evicts 0x0021 in way0
        do_access(16'h0011, KIND_SLOW, 0, 1'b0, "R7");   // survivor
        do_access(16'h0021, KIND_MISS, 1, 1'b0, "R7");   // was displaced
        do_access(16'h0005, KIND_MISS, 3, 1'b0, "R6");
        do_access(16'h0005, KIND_FAST, 0, 1'b0, "R2");
        test_busy_ignore();
        test_stray_valid();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule